// File: doc/BRIEF.md
# Method Group Assembler

This block gathers the register-write traffic of a macro execution engine into groups and replays each group as a series of address/data writes. A header event opens a group. Its low twelve bits give a method word address, so the byte address is those bits shifted left by two. Its next four bits give an increment code, which is kept with the group. Emit events then append 32-bit data words to the open group, up to a fixed depth.

A group is drained in three cases: on an explicit flush request, when a new header arrives while a group is open, or when a state read is requested while a group is open. During a drain, one write per buffered word goes out on a valid/ready stream, and the address steps by four bytes for each word. Any write whose address lands inside a scratch window is also stored in a local scratch array. A state read returns the scratch entry for its address, or zero when the address is outside the window. Because an open group is drained before the read completes, the value returned always includes the writes that were still pending.

Top module: `method_group_assembler`

## Requirements
- R1: After reset, busy, out_valid, emit_err and rd_done are all low, and no group is open.
- R2: A header word h opens a group whose first output address is {h[11:0], 2'b00}, and out_inc shows h[15:12] from the cycle after the header.
- R3: An open group buffers up to 8 data words. The drain sends exactly the accepted words, in emit order.
- R4: Within one drain, each output address is the previous one plus 4.
- R5: An emit while no group is open, or while the group already holds 8 words, pulses emit_err in the following cycle and the word is dropped, so it never appears on the output.
- R6: A header that arrives while a group is open first drains that group completely. It then opens the new group with zero words.
- R7: A flush with no open group produces no output and leaves busy low. A flush of an open but empty group produces no output and closes the group, so a later emit is refused.
- R8: While out_valid is high and out_ready is low, out_valid, out_addr and out_data hold steady. busy stays high from the cycle after a drain starts until every word has been accepted.
- R9: A drained write whose address a satisfies 0x3400 <= a < 0x3800 stores its data in scratch entry (a - 0x3400)/4. Writes outside that range leave the scratch array untouched.
- R10: A read at byte address a pulses rd_done with rd_data set to the scratch entry (a - 0x3400)/4 inside the window, or to zero outside it. If a group is open, that group is drained before rd_done, and the returned value reflects the drain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hdr_valid | input | 1 | Header event strobe |
| hdr_word | input | 16 | Header: [11:0] method word address, [15:12] increment code |
| emit_valid | input | 1 | Emit event strobe |
| emit_data | input | 32 | Data word to append |
| flush_req | input | 1 | Drain the open group |
| rd_req | input | 1 | State read strobe |
| rd_addr | input | 16 | State read byte address |
| rd_done | output | 1 | One-cycle read completion pulse |
| rd_data | output | 32 | State read result |
| out_valid | output | 1 | Output write valid |
| out_ready | input | 1 | Output write accepted |
| out_addr | output | 16 | Output write byte address |
| out_data | output | 32 | Output write data |
| out_inc | output | 4 | Increment code of the current group |
| busy | output | 1 | Drain in progress |
| emit_err | output | 1 | One-cycle pulse for a dropped emit |

## Verification
The assertions assume that at most one event strobe is high in a cycle, that events arrive only while busy is low, and that each strobe lasts a single cycle. The assertions on output holding and address stepping rely on these assumptions. The bench drives every event from a task that sets one strobe at a falling edge and clears it at the next. After each flush, header or read that may start a drain, the bench waits for busy to fall before it issues another event. The output stall test toggles out_ready in a fixed pattern, while the order of the events stays the same.

// File: rtl/mga_pkg.sv
package mga_pkg;
   typedef enum logic {ST_IDLE, ST_DRAIN} mga_state_e;
   localparam int unsigned WORD_STEP_B = 4;
endpackage

// File: rtl/mga_group_buf.sv
module mga_group_buf #(
   parameter int unsigned DW    = 32,
   parameter int unsigned DEPTH = 8,
   localparam int unsigned LEN_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             we,
   input  logic [DW-1:0]    wdata,
   input  logic [LEN_W-1:0] ridx,
   output logic [LEN_W-1:0] len,
   output logic             full,
   output logic [DW-1:0]    rdata
);
   logic [DW-1:0] words [DEPTH];

   for (genvar g = 0; g < DEPTH; g++) begin : g_word
      always_ff @(posedge clk) begin
         if (we && len == LEN_W'(g)) words[g] <= wdata;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clr) len <= '0;
      else if (we)       len <= len + LEN_W'(1);
   end

   assign full  = (len == LEN_W'(DEPTH));
   assign rdata = (ridx < LEN_W'(DEPTH)) ? words[ridx] : '0;

   AST_LEN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      len <= LEN_W'(DEPTH)); // R3
endmodule

// File: rtl/mga_scratch.sv
module mga_scratch #(
   parameter int unsigned DW    = 32,
   parameter int unsigned N     = 256,
   parameter bit          CLEAR = 1'b1,
   localparam int unsigned IW   = $clog2(N)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [IW-1:0] widx,
   input  logic [DW-1:0] wdata,
   input  logic [IW-1:0] ridx,
   output logic [DW-1:0] rdata
);
   logic [DW-1:0] mem [N];

   if (CLEAR) begin : g_clear
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            for (int i = 0; i < N; i++) mem[i] <= '0;
         end else if (we) begin
            mem[widx] <= wdata;
         end
      end
   end else begin : g_plain
      always_ff @(posedge clk) begin
         if (we) mem[widx] <= wdata;
      end
   end

   assign rdata = mem[ridx];
endmodule

// File: rtl/method_group_assembler.sv
module method_group_assembler
   import mga_pkg::*;
#(
   parameter int unsigned DW       = 32,
   parameter int unsigned AW       = 16,
   parameter int unsigned HDR_AF   = 12,
   parameter int unsigned INC_W    = 4,
   parameter int unsigned DEPTH    = 8,
   parameter int unsigned SCR_N    = 256,
   parameter int unsigned SCR_BASE = 16'h3400,
   localparam int unsigned HW      = HDR_AF + INC_W,
   localparam int unsigned LEN_W   = $clog2(DEPTH + 1),
   localparam int unsigned SCR_IW  = $clog2(SCR_N)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hdr_valid,
   input  logic [HW-1:0]    hdr_word,
   input  logic             emit_valid,
   input  logic [DW-1:0]    emit_data,
   input  logic             flush_req,
   input  logic             rd_req,
   input  logic [AW-1:0]    rd_addr,
   output logic             rd_done,
   output logic [DW-1:0]    rd_data,
   output logic             out_valid,
   input  logic             out_ready,
   output logic [AW-1:0]    out_addr,
   output logic [DW-1:0]    out_data,
   output logic [INC_W-1:0] out_inc,
   output logic             busy,
   output logic             emit_err
);
   localparam logic [AW:0] WIN_LO = (AW+1)'(SCR_BASE);
   localparam logic [AW:0] WIN_HI = (AW+1)'(SCR_BASE + SCR_N * WORD_STEP_B);

   if (AW < HDR_AF + 2) begin : g_bad_aw
      $error("address width too small for header field");
   end
   if (DEPTH < 1) begin : g_bad_depth
      $error("group depth must be at least one");
   end
   if ((SCR_BASE % WORD_STEP_B) != 0 || SCR_BASE + SCR_N * WORD_STEP_B > (1 << AW)) begin : g_bad_win
      $error("scratch window misaligned or out of range");
   end

   function automatic logic in_win(input logic [AW-1:0] a);
      return ({1'b0, a} >= WIN_LO) && ({1'b0, a} < WIN_HI);
   endfunction

   function automatic logic [SCR_IW-1:0] win_idx(input logic [AW-1:0] a);
      return SCR_IW'((a - AW'(SCR_BASE)) >> 2);
   endfunction

   mga_state_e       state;
   logic             pend, reopen, rd_wait;
   logic [AW-1:0]    base;
   logic [HW-1:0]    nxt_hdr;
   logic [AW-1:0]    rd_addr_q;
   logic [LEN_W-1:0] idx, len;
   logic             full, buf_we, buf_clr, done_drain;
   logic [DW-1:0]    buf_rdata, scr_rdata;
   logic [AW-1:0]    rd_sel;
   logic             idle;

   assign idle       = (state == ST_IDLE);
   assign done_drain = (state == ST_DRAIN) && (idx == len);
   assign buf_we     = idle && !hdr_valid && emit_valid && pend && !full;
   assign buf_clr    = (idle && hdr_valid && !pend) || (done_drain && reopen);

   mga_group_buf #(.DW(DW), .DEPTH(DEPTH)) u_buf (
      .clk(clk), .rst_n(rst_n), .clr(buf_clr), .we(buf_we), .wdata(emit_data),
      .ridx(idx), .len(len), .full(full), .rdata(buf_rdata)
   );

   assign out_valid = (state == ST_DRAIN) && (idx != len);
   assign out_addr  = base + AW'({idx, 2'b00});
   assign out_data  = buf_rdata;
   assign busy      = !idle;
   assign rd_sel    = idle ? rd_addr : rd_addr_q;

   mga_scratch #(.DW(DW), .N(SCR_N), .CLEAR(1'b1)) u_scr (
      .clk(clk), .rst_n(rst_n),
      .we(out_valid && out_ready && in_win(out_addr)),
      .widx(win_idx(out_addr)), .wdata(out_data),
      .ridx(win_idx(rd_sel)), .rdata(scr_rdata)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         pend      <= 1'b0;
         reopen    <= 1'b0;
         rd_wait   <= 1'b0;
         base      <= '0;
         out_inc   <= '0;
         nxt_hdr   <= '0;
         rd_addr_q <= '0;
         idx       <= '0;
         rd_done   <= 1'b0;
         rd_data   <= '0;
         emit_err  <= 1'b0;
      end else begin
         rd_done  <= 1'b0;
         emit_err <= 1'b0;
         if (idle) begin
            if (hdr_valid) begin
               if (pend) begin
                  nxt_hdr <= hdr_word;
                  reopen  <= 1'b1;
                  idx     <= '0;
                  state   <= ST_DRAIN;
               end else begin
                  base    <= AW'({hdr_word[HDR_AF-1:0], 2'b00});
                  out_inc <= hdr_word[HW-1:HDR_AF];
                  pend    <= 1'b1;
               end
            end else if (emit_valid) begin
               if (!pend || full) emit_err <= 1'b1;
            end else if (flush_req) begin
               if (pend) begin
                  idx   <= '0;
                  state <= ST_DRAIN;
               end
            end else if (rd_req) begin
               if (pend) begin
                  rd_wait   <= 1'b1;
                  rd_addr_q <= rd_addr;
                  idx       <= '0;
                  state     <= ST_DRAIN;
               end else begin
                  rd_done <= 1'b1;
                  rd_data <= in_win(rd_addr) ? scr_rdata : '0;
               end
            end
         end else if (done_drain) begin
            state <= ST_IDLE;
            pend  <= reopen;
            if (reopen) begin
               base    <= AW'({nxt_hdr[HDR_AF-1:0], 2'b00});
               out_inc <= nxt_hdr[HW-1:HDR_AF];
               reopen  <= 1'b0;
            end
            if (rd_wait) begin
               rd_done <= 1'b1;
               rd_data <= in_win(rd_addr_q) ? scr_rdata : '0;
               rd_wait <= 1'b0;
            end
         end else if (out_ready) begin
            idx <= idx + LEN_W'(1);
         end
      end
   end

   AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_addr) && $stable(out_data))); // R8
   AST_VALID_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> busy); // R8
   AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_ready) |=> (!out_valid || out_addr == $past(out_addr) + AW'(WORD_STEP_B))); // R4
   AST_RD_AFTER_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
      rd_done |-> !busy); // R10
endmodule

// File: tb/method_group_assembler_tb_top.sv
module method_group_assembler_tb_top;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        hdr_valid = 0, emit_valid = 0, flush_req = 0, rd_req = 0;
   logic [15:0] hdr_word = 0, rd_addr = 0;
   logic [31:0] emit_data = 0;
   logic        rd_done, out_valid, busy, emit_err;
   logic        out_ready = 1'b1;
   logic [31:0] rd_data, out_data;
   logic [15:0] out_addr;
   logic [3:0]  out_inc;

   int checks = 0, errors = 0;
   logic [15:0] cap_addr [64];
   logic [31:0] cap_data [64];
   int cap_n = 0, hold_bad = 0, rdy_cnt = 0;
   logic stall_en = 1'b0;
   logic prev_v = 0, prev_r = 0;
   logic [15:0] prev_a = 0;
   logic [31:0] prev_d = 0;

   always #5 clk = ~clk;

   method_group_assembler dut_i (
      .clk(clk), .rst_n(rst_n), .hdr_valid(hdr_valid), .hdr_word(hdr_word),
      .emit_valid(emit_valid), .emit_data(emit_data), .flush_req(flush_req),
      .rd_req(rd_req), .rd_addr(rd_addr), .rd_done(rd_done), .rd_data(rd_data),
      .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr),
      .out_data(out_data), .out_inc(out_inc), .busy(busy), .emit_err(emit_err)
   );

   always @(negedge clk) begin
      if (prev_v && !prev_r &&
          !(out_valid && out_addr == prev_a && out_data == prev_d)) hold_bad++;
      if (stall_en) begin
         out_ready = (rdy_cnt % 3 == 2);
         rdy_cnt++;
      end else out_ready = 1'b1;
      if (out_valid && out_ready && cap_n < 64) begin
         cap_addr[cap_n] = out_addr;
         cap_data[cap_n] = out_data;
         cap_n++;
      end
      prev_v = out_valid; prev_r = out_ready; prev_a = out_addr; prev_d = out_data;
   end

   task automatic check(input logic ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic send_hdr(input logic [15:0] h);
      @(negedge clk); hdr_valid = 1; hdr_word = h;
      @(negedge clk); hdr_valid = 0;
   endtask

   task automatic send_emit(input logic [31:0] d, input logic exp_err, input string tag);
      @(negedge clk); emit_valid = 1; emit_data = d;
      @(negedge clk); emit_valid = 0;
      check(emit_err == exp_err, tag, emit_err, exp_err);
   endtask

   task automatic wait_idle();
      for (int i = 0; i < 200 && busy; i++) @(negedge clk);
   endtask

   task automatic send_flush();
      @(negedge clk); flush_req = 1;
      @(negedge clk); flush_req = 0;
      wait_idle();
   endtask

   task automatic do_read(input logic [15:0] a, input logic [31:0] exp, input string tag);
      @(negedge clk); rd_req = 1; rd_addr = a;
      @(negedge clk); rd_req = 0;
      for (int i = 0; i < 100 && !rd_done; i++) @(negedge clk);
      check(rd_done == 1'b1, {tag, " done"}, rd_done, 1);
      check(rd_data == exp, tag, rd_data, exp);
   endtask

   task automatic expect_out(input int n, input logic [15:0] a0, input logic [31:0] d0, input string tag);
      check(cap_n == n, {tag, " count"}, cap_n, n);
      for (int i = 0; i < n && i < cap_n; i++) begin
         check(cap_addr[i] == a0 + 16'(4 * i), {tag, " addr"}, cap_addr[i], a0 + 16'(4 * i));
         check(cap_data[i] == d0 + 32'(i), {tag, " data"}, cap_data[i], d0 + 32'(i));
      end
   endtask

   task automatic t_reset();
      check(!busy && !out_valid && !emit_err && !rd_done, "R1 reset outputs",
            {busy, out_valid, emit_err, rd_done}, 0);
      send_emit(32'h1, 1'b1, "R1 no group after reset");
   endtask

   task automatic t_basic();
      cap_n = 0;
      send_hdr(16'h1010);
      check(out_inc == 4'h1, "R2 inc field", out_inc, 1);
      for (int i = 0; i < 3; i++) send_emit(32'h100 + 32'(i), 1'b0, "R3 emit ok");
      send_flush();
      expect_out(3, 16'h0040, 32'h100, "R2 R3 R4 basic");
   endtask

   task automatic t_full();
      cap_n = 0;
      send_hdr(16'h2123);
      check(out_inc == 4'h2, "R2 inc field", out_inc, 2);
      for (int i = 0; i < 8; i++) send_emit(32'h200 + 32'(i), 1'b0, "R3 emit ok");
      send_emit(32'hDEAD, 1'b1, "R5 full emit");
      send_flush();
      expect_out(8, 16'h048C, 32'h200, "R3 R5 full group");
      send_emit(32'hBEEF, 1'b1, "R5 emit after close");
      cap_n = 0;
      send_flush();
      check(cap_n == 0 && !busy, "R7 flush with none open", cap_n, 0);
   endtask

   task automatic t_replace();
      cap_n = 0;
      send_hdr(16'h0100);
      send_emit(32'h300, 1'b0, "R6 emit a");
      send_emit(32'h301, 1'b0, "R6 emit a");
      send_hdr(16'h3200);
      wait_idle();
      expect_out(2, 16'h0400, 32'h300, "R6 old group first");
      check(out_inc == 4'h3, "R6 new inc", out_inc, 3);
      cap_n = 0;
      send_emit(32'h400, 1'b0, "R6 emit b");
      send_flush();
      expect_out(1, 16'h0800, 32'h400, "R6 new group from zero");
   endtask

   task automatic t_stall();
      int hi;
      cap_n = 0; hold_bad = 0; hi = 0;
      send_hdr(16'h0020);
      for (int i = 0; i < 5; i++) send_emit(32'h500 + 32'(i), 1'b0, "R8 emit");
      stall_en = 1; rdy_cnt = 0;
      @(negedge clk); flush_req = 1;
      @(negedge clk); flush_req = 0;
      for (int i = 0; i < 200 && busy; i++) begin
         hi++;
         @(negedge clk);
      end
      stall_en = 0;
      check(hi > 5, "R8 busy held during stall", hi, 6);
      check(cap_n == 5, "R8 all accepted when busy falls", cap_n, 5);
      check(hold_bad == 0, "R8 hold while not ready", hold_bad, 0);
      expect_out(5, 16'h0080, 32'h500, "R8 R4 stalled drain");
   endtask

   task automatic t_scratch();
      cap_n = 0;
      send_hdr(16'h0D05);
      for (int i = 0; i < 3; i++) send_emit(32'hA5 + 32'(i), 1'b0, "R9 emit");
      do_read(16'h3418, 32'hA6, "R10 read drains first");
      check(cap_n == 3, "R10 drain before read", cap_n, 3);
      do_read(16'h3414, 32'hA5, "R9 entry five");
      do_read(16'h0100, 32'h0, "R10 outside window");
      send_hdr(16'h0DFE);
      for (int i = 0; i < 3; i++) send_emit(32'hB0 + 32'(i), 1'b0, "R9 emit edge");
      send_flush();
      do_read(16'h37FC, 32'hB1, "R9 last entry");
      do_read(16'h3800, 32'h0, "R9 past window end");
   endtask

   task automatic t_empty();
      cap_n = 0;
      send_hdr(16'h0011);
      send_flush();
      check(cap_n == 0, "R7 empty group no output", cap_n, 0);
      send_emit(32'h77, 1'b1, "R7 group closed");
   endtask

   initial begin
      #1_000_000;
      errors++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      rst_n = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_basic();
      t_full();
      t_replace();
      t_stall();
      t_scratch();
      t_empty();
      repeat (3) @(negedge clk);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule